// File: doc/BRIEF.md
# Oversampling Serial Receiver with Noise Flag

This block recovers 8-bit characters from an asynchronous serial line. It uses a tick enable that runs at sixteen times the bit rate, so every bit time is sixteen slots long (slot 1 to slot 16). The receiver waits for a high-to-low transition that follows at least three high samples. It confirms the start bit with a majority vote over three early slots. It then decides each bit by a majority over three slots near the middle of the bit.

The receiver re-aligns its slot counter on every qualifying falling edge, both in idle and inside a frame. This lets it follow a transmitter whose bit rate is somewhat off. It reports three things with each character: whether any sample disagreed with the value decided for its bit, whether the stop bit was low, and whether the frame was a line break. A framing error is sticky. While it is set, completed characters are dropped, until software pulses the clear input.

Top module: `ovs_uart_rx`

## Requirements
- R1: The line passes through a two-stage synchronizer. A falling edge counts only when a low sample follows three consecutive high samples. A low line with fewer than three high samples before a low never starts a frame. After reset the sample history holds no high samples.
- R2: After an idle edge (slot 1), slots 3, 5 and 7 are sampled. The start is accepted when at least two of these are low. Otherwise the receiver returns to edge search and delivers nothing.
- R3: Each bit is decided by the majority of slots 8, 9 and 10. The frame is a start bit, 8 data bits sent least significant bit first, then one stop bit. An accepted start bit is taken as 0 even when its slot 8 to 10 samples are high.
- R4: `noiseFlag` is high with a delivered character when any sample taken in any bit of that frame differed from the bit's decided value. The samples taken are slots 3/5/7/8/9/10 for the start bit and slots 8/9/10 for the other bits.
- R5: Inside a frame, a qualifying falling edge makes the current tick slot 1. If it comes after slot 10 of the current bit, it also starts the next bit.
- R6: A stop bit decided low sets `frameErr`. That frame is still delivered if the flag was clear before it. The flag stays set until a `feClr` pulse. A new framing error in the same cycle as `feClr` wins over the clear.
- R7: A frame with all data bits and the stop bit low is delivered with `breakFlag` high, `rxData` equal to 0x00 and `frameErr` set.
- R8: After a framing error on a frame that is not a break, the edge history is filled with high samples. A line that is still low at the next tick is therefore taken as a new start edge.
- R9: While `frameErr` is set, frames are still shifted in but no character is delivered.
- R10: `rxValid` is a one-cycle pulse per delivered character. `noiseFlag` and `breakFlag` are high only together with it.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| rxd | input | 1 | Raw serial line, idle high |
| feClr | input | 1 | Pulse that clears the framing error flag |
| rxData | output | 8 | Received character |
| rxValid | output | 1 | One-cycle pulse marking a delivered character |
| noiseFlag | output | 1 | Sample disagreement in the delivered frame |
| breakFlag | output | 1 | Delivered frame was a line break |
| frameErr | output | 1 | Sticky framing error flag |

## Verification
The hardest state to reach from the ports is the edge-history preload after a framing error. Its only visible effect is that a start bit glued directly onto a low stop bit is captured six slots early, and the block must still decode it correctly. The stimulus sends a frame with a low stop bit, follows it at once with a second frame, and pulses the clear in the middle of that second frame so the character can be delivered and compared. Re-alignment is reached by sending an alternating byte with bits two slots short, where only the edges inside the frame keep the stop bit inside its sampling window.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

  // Oversampling ratio and slot positions (slot index = RT number - 1)
  localparam int unsigned OVS = 16;
  localparam int unsigned SLOT_W = $clog2(OVS);
  localparam logic [SLOT_W-1:0] SLOT_V1   = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] SLOT_V2   = SLOT_W'(4);
  localparam logic [SLOT_W-1:0] SLOT_V3   = SLOT_W'(6);
  localparam logic [SLOT_W-1:0] SLOT_M1   = SLOT_W'(7);
  localparam logic [SLOT_W-1:0] SLOT_M2   = SLOT_W'(8);
  localparam logic [SLOT_W-1:0] SLOT_M3   = SLOT_W'(9);
  localparam logic [SLOT_W-1:0] SLOT_LATE = SLOT_W'(10);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(OVS - 1);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_e;

  typedef struct packed {
    logic frameBegin;
    logic voteA;
    logic voteB;
    logic voteC;
    logic midA;
    logic midB;
    logic decide;
    logic startBit;
    logic stopBit;
  } rxStrobe_t;

endpackage

// File: rtl/ovs_rx_ctrl.sv
module ovs_rx_ctrl
  import ovs_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      edgeSeen,
  input  logic      startOk,
  output rxStrobe_t stb
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rxState_e          st, stNx;
  logic [SLOT_W-1:0] slot, slotNx;
  logic [IDX_W-1:0]  idx, idxNx;
  logic              adv;

  always_comb begin
    stNx   = st;
    idxNx  = idx;
    slotNx = slot;
    stb    = '0;
    adv    = 1'b0;
    if (tick) begin
      if (st == RX_IDLE) begin
        if (edgeSeen) begin
          stNx           = RX_START;
          slotNx         = '0;
          stb.frameBegin = 1'b1;
        end
      end else begin
        // an edge late in a bit opens the next bit; early, it re-aligns the current one
        adv    = edgeSeen ? (slot >= SLOT_LATE) : (slot == SLOT_LAST);
        slotNx = edgeSeen ? '0 : slot + 1'b1;
        if (adv) begin
          unique case (st)
            RX_START: begin
              stNx  = RX_DATA;
              idxNx = '0;
            end
            RX_DATA: begin
              if (idx == LAST_IDX) stNx = RX_STOP;
              else idxNx = idx + 1'b1;
            end
            default: stNx = RX_IDLE;
          endcase
        end
        if (stNx != RX_IDLE) begin
          stb.startBit = (stNx == RX_START);
          stb.stopBit  = (stNx == RX_STOP);
          if (stNx == RX_START) begin
            stb.voteA = (slotNx == SLOT_V1);
            stb.voteB = (slotNx == SLOT_V2);
            stb.voteC = (slotNx == SLOT_V3);
            if (stb.voteC && !startOk) stNx = RX_IDLE;
          end
          stb.midA   = (slotNx == SLOT_M1);
          stb.midB   = (slotNx == SLOT_M2);
          stb.decide = (slotNx == SLOT_M3) && (stNx != RX_IDLE);
          if (stb.decide && stb.stopBit) stNx = RX_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      slot <= '0;
      idx  <= '0;
    end else begin
      st   <= stNx;
      slot <= slotNx;
      idx  <= idxNx;
    end
  end

endmodule

// File: rtl/ovs_rx_dpath.sv
module ovs_rx_dpath
  import ovs_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic              feClr,
  input  rxStrobe_t         stb,
  output logic              edgeSeen,
  output logic              startOk,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              noiseFlag,
  output logic              breakFlag,
  output logic              frameErr
);

  logic sample;

  generate
    if (SYNC_N <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk) begin
        if (rst) syncQ <= 1'b1;
        else     syncQ <= rxd;
      end
      assign sample = syncQ;
    end else begin : g_syncN
      logic [SYNC_N-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '1;
        else     syncQ <= {syncQ[SYNC_N-2:0], rxd};
      end
      assign sample = syncQ[SYNC_N-1];
    end
  endgenerate

  logic [2:0]        hist;
  logic              vA, vB, vC, mA, mB;
  logic              noiseAcc;
  logic [DATA_W-1:0] shiftQ;
  logic              bitVal, disagree, finish, isFe, isBrk, deliver;

  assign edgeSeen = tick && !sample && (&hist);
  assign startOk  = (!vA && !vB) || (!vA && !sample) || (!vB && !sample);

  always_comb begin
    if (stb.startBit) begin
      bitVal   = 1'b0;
      disagree = vA | vB | vC | mA | mB | sample;
    end else begin
      bitVal   = (mA & mB) | (mA & sample) | (mB & sample);
      disagree = (mA != bitVal) | (mB != bitVal) | (sample != bitVal);
    end
  end

  assign finish  = stb.decide && stb.stopBit;
  assign isFe    = finish && !bitVal;
  assign isBrk   = isFe && (shiftQ == '0);
  assign deliver = finish && !frameErr;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (tick) begin
      if (isFe && !isBrk) hist <= 3'b111;
      else                hist <= {hist[1:0], sample};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vA       <= 1'b1;
      vB       <= 1'b1;
      vC       <= 1'b1;
      mA       <= 1'b1;
      mB       <= 1'b1;
      noiseAcc <= 1'b0;
      shiftQ   <= '0;
    end else begin
      if (stb.voteA) vA <= sample;
      if (stb.voteB) vB <= sample;
      if (stb.voteC) vC <= sample;
      if (stb.midA)  mA <= sample;
      if (stb.midB)  mB <= sample;
      if (stb.frameBegin)  noiseAcc <= 1'b0;
      else if (stb.decide) noiseAcc <= noiseAcc | disagree;
      if (stb.decide && !stb.startBit && !stb.stopBit)
        shiftQ <= {bitVal, shiftQ[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxData    <= '0;
      rxValid   <= 1'b0;
      noiseFlag <= 1'b0;
      breakFlag <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      rxValid   <= deliver;
      noiseFlag <= deliver && (noiseAcc | disagree);
      breakFlag <= deliver && isBrk;
      if (deliver) rxData <= shiftQ;
      if (isFe)       frameErr <= 1'b1;
      else if (feClr) frameErr <= 1'b0;
    end
  end

endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx
  import ovs_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              feClr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              noiseFlag,
  output logic              breakFlag,
  output logic              frameErr
);

  rxStrobe_t stb;
  logic      edgeSeen;
  logic      startOk;

  ovs_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick16),
    .edgeSeen (edgeSeen),
    .startOk  (startOk),
    .stb      (stb)
  );

  ovs_rx_dpath #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick16),
    .rxd       (rxd),
    .feClr     (feClr),
    .stb       (stb),
    .edgeSeen  (edgeSeen),
    .startOk   (startOk),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .noiseFlag (noiseFlag),
    .breakFlag (breakFlag),
    .frameErr  (frameErr)
  );

endmodule

// File: rtl/ovs_uart_rx_chk.sv
module ovs_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              feClr,
  input logic [DATA_W-1:0] rxData,
  input logic              rxValid,
  input logic              noiseFlag,
  input logic              breakFlag,
  input logic              frameErr
);

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  // R10
  noise_qual_chk: assert property (@(posedge clk) disable iff (rst)
    noiseFlag |-> rxValid);

  // R7
  break_shape_chk: assert property (@(posedge clk) disable iff (rst)
    breakFlag |-> (rxValid && rxData == '0 && frameErr));

  // R6
  fe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frameErr) |-> rxValid);

  // R6
  fe_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(frameErr) |-> $past(feClr));

  // R9
  fe_block_chk: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> !$past(frameErr));

endmodule

bind ovs_uart_rx ovs_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .feClr     (feClr),
  .rxData    (rxData),
  .rxValid   (rxValid),
  .noiseFlag (noiseFlag),
  .breakFlag (breakFlag),
  .frameErr  (frameErr)
);

// File: tb/ovs_uart_rx_test.sv
module ovs_uart_rx_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b0;
  logic       feClr = 1'b0;
  logic [7:0] rxData;
  logic       rxValid, noiseFlag, breakFlag, frameErr;

  ovs_uart_rx uut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .feClr(feClr),
    .rxData(rxData), .rxValid(rxValid), .noiseFlag(noiseFlag),
    .breakFlag(breakFlag), .frameErr(frameErr)
  );

  always #10 clk = ~clk;  // 50 MHz

  int   nChecks = 0;
  int   nFail = 0;
  int   gotCnt = 0;
  int   pulseBad = 0;
  logic prevValid = 1'b0;
  bit   done = 1'b0;
  logic [7:0] logData  [0:127];
  logic       logNoise [0:127];
  logic       logBrk   [0:127];
  logic       logFe    [0:127];

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (rxValid && gotCnt < 128) begin
        logData[gotCnt]  = rxData;
        logNoise[gotCnt] = noiseFlag;
        logBrk[gotCnt]   = breakFlag;
        logFe[gotCnt]    = frameErr;
      end
      if (rxValid) gotCnt++;
      if (rxValid && prevValid) pulseBad++;
      if ((noiseFlag || breakFlag) && !rxValid) pulseBad++;
      prevValid = rxValid;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] frameBits(input logic [7:0] d, input logic stopV);
    return {stopV, d, 1'b0};
  endfunction

  // one oversampling slot: line value applied, tick on the fourth clock
  task automatic slot(input logic v, input logic clr);
    rxd = v;
    feClr = clr;
    @(negedge clk);
    feClr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1, 1'b0);
  endtask

  // glBit < 0: no glitch; startLow: low slots of the start bit; clrBit: feClr at that bit
  task automatic sendFrame(input logic [7:0] d, input logic stopV, input int glBit,
                           input int glOff, input int perBit, input int startLow,
                           input int clrBit);
    logic [9:0] fb;
    fb = frameBits(d, stopV);
    for (int k = 0; k < 10; k++) begin
      for (int o = 0; o < perBit; o++) begin
        logic v;
        v = fb[k];
        if (k == 0 && o >= startLow) v = 1'b1;
        if (k == glBit && o == glOff) v = ~v;
        slot(v, (k == clrBit) && (o == 0));
      end
    end
  endtask

  task automatic expectChar(input string req, input int idx, input logic [7:0] d,
                            input logic nz, input logic br, input logic fe);
    check(req, "delivered count", gotCnt, idx + 1);
    if (gotCnt > idx) begin
      check(req, "data", logData[idx], d);
      check(req, "noise flag", logNoise[idx], nz);
      check(req, "break flag", logBrk[idx], br);
      check(req, "frame error", logFe[idx], fe);
    end
  endtask

  initial begin
    int base;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R11 reset state
    check("R11", "rxValid", rxValid, 0);
    check("R11", "frameErr", frameErr, 0);
    check("R11", "noiseFlag", noiseFlag, 0);
    check("R11", "breakFlag", breakFlag, 0);
    rst = 1'b0;

    // R1: line low from reset, two high slots, low again: no edge qualifies
    for (int i = 0; i < 30; i++) slot(1'b0, 1'b0);
    idle(2);
    for (int i = 0; i < 200; i++) slot(1'b0, 1'b0);
    idle(30);
    check("R1", "no frame without three highs", gotCnt, 0);
    check("R1", "frameErr after short highs", frameErr, 0);

    // R3 clean frame
    base = gotCnt;
    sendFrame(8'hA5, 1'b1, -1, 0, 16, 16, -1);
    idle(4);
    expectChar("R3", base, 8'hA5, 1'b0, 1'b0, 1'b0);

    // R2 failed start vote: low only for slots 1..3
    base = gotCnt;
    for (int i = 0; i < 3; i++) slot(1'b0, 1'b0);
    idle(200);
    check("R2", "rejected start delivers nothing", gotCnt, base);
    sendFrame(8'h5A, 1'b1, -1, 0, 16, 16, -1);
    idle(4);
    expectChar("R2", base, 8'h5A, 1'b0, 1'b0, 1'b0);

    // R3/R4 start bit low only in slots 1..5: vote passes, mid samples high
    base = gotCnt;
    sendFrame(8'h3C, 1'b1, -1, 0, 16, 5, -1);
    idle(4);
    expectChar("R3", base, 8'h3C, 1'b1, 1'b0, 1'b0);

    // R4 one-slot glitch at slot 9 of data bit 1 (a zero bit of 0xF0)
    base = gotCnt;
    sendFrame(8'hF0, 1'b1, 2, 8, 16, 16, -1);
    idle(4);
    expectChar("R4", base, 8'hF0, 1'b1, 1'b0, 1'b0);

    // R5 short bits (14 slots): edges inside the frame keep alignment
    base = gotCnt;
    sendFrame(8'h55, 1'b1, -1, 0, 14, 14, -1);
    idle(6);
    expectChar("R5", base, 8'h55, 1'b0, 1'b0, 1'b0);

    // R6 framing error frame is delivered and the flag sticks
    base = gotCnt;
    sendFrame(8'hA5, 1'b0, -1, 0, 16, 16, -1);
    idle(170);
    expectChar("R6", base, 8'hA5, 1'b0, 1'b0, 1'b1);
    check("R6", "frameErr sticky", frameErr, 1);

    // R9 blocked while the flag is set
    sendFrame(8'h3C, 1'b1, -1, 0, 16, 16, -1);
    idle(10);
    check("R9", "no delivery while frameErr", gotCnt, base + 1);
    check("R9", "frameErr still set", frameErr, 1);
    slot(1'b1, 1'b1);
    check("R6", "frameErr cleared by feClr", frameErr, 0);
    idle(4);
    base = gotCnt;
    sendFrame(8'h3C, 1'b1, -1, 0, 16, 16, -1);
    idle(4);
    expectChar("R9", base, 8'h3C, 1'b0, 1'b0, 1'b0);

    // R8 framing error followed at once by a frame; clear during the second
    base = gotCnt;
    sendFrame(8'hA5, 1'b0, -1, 0, 16, 16, -1);
    sendFrame(8'h3C, 1'b1, -1, 0, 16, 16, 3);
    idle(6);
    check("R8", "both frames delivered", gotCnt, base + 2);
    if (gotCnt >= base + 2) begin
      check("R8", "first frame error", logFe[base], 1);
      check("R8", "glued frame data", logData[base + 1], 8'h3C);
      check("R8", "glued frame noise", logNoise[base + 1], 0);
    end
    check("R8", "frameErr after clear", frameErr, 0);

    // R7 break
    base = gotCnt;
    sendFrame(8'h00, 1'b0, -1, 0, 16, 16, -1);
    idle(200);
    expectChar("R7", base, 8'h00, 1'b0, 1'b1, 1'b1);
    slot(1'b1, 1'b1);
    idle(4);
    check("R7", "frameErr cleared after break", frameErr, 0);

    // R3/R4 random frames with optional single-slot glitches
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      logic [9:0] fb;
      int gb, go, pick;
      logic expN;
      d = 8'($urandom_range(0, 255));
      fb = frameBits(d, 1'b1);
      gb = $urandom_range(0, 11);
      go = 0;
      expN = 1'b0;
      if (gb == 0) begin
        pick = $urandom_range(0, 5);
        go = (pick < 3) ? 2 + 2 * pick : 4 + pick;
        expN = 1'b1;
      end else if (gb <= 8 && fb[gb] == 1'b0) begin
        go = $urandom_range(7, 9);
        expN = 1'b1;
      end else begin
        gb = -1;
      end
      base = gotCnt;
      sendFrame(d, 1'b1, gb, go, 16, 16, -1);
      idle($urandom_range(3, 6));
      expectChar(expN ? "R4" : "R3", base, d, expN, 1'b0, 1'b0);
    end

    // R10 pulse shape over the whole run
    check("R10", "valid pulse width and flag qualification", pulseBad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R10 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule